// File: doc/BRIEF.md
# ADC Trigger and Gate Unit

This block decides when paced analog-to-digital conversions may start or keep running. It picks one of three trigger origins (a software strobe, an external digital pin, or a pair of analog comparator results), conditions the chosen signal, and produces a conversion-gate output. It also keeps a readable flag that records that a trigger has been taken.

External signals can be inverted and then used either as a rising-edge trigger or as a high-level gate. The comparator pair reports "input above the high threshold" and "input below the low threshold". These two results feed a small analog function unit. That unit forms a hysteresis, slope or window signal from them. A captured trigger is one-shot: later triggers are ignored until software writes the clear bit.

The external pin and both comparator results cross into the clock domain through a synchronizer chain whose length is a parameter. The comparators, threshold generators and pacer counters live outside this block.

Top module: `adc_trig_gate`

## Requirements
- R1: After reset, `conv_gate` and `trig_captured` are both 0.
- R2: With `src_sel` = 00 (disabled), `conv_gate` stays 0 and `trig_captured` never becomes set, whatever the other inputs do.
- R3: With `src_sel` = 01 (software), a one-cycle `sw_trig` pulse sets `trig_captured` at the next clock edge whether `ext_en` is set or not. In this source `conv_gate` equals `trig_captured`.
- R4: With `src_sel` = 10 (digital pin) or 11 (analog), nothing changes while `ext_en` is 0: `conv_gate` stays 0 and no capture occurs.
- R5: `polarity` = 1 inverts the external signal before edge or level handling, so a falling pin edge triggers and a low pin opens the gate.
- R6: With `edge_mode` = 1, a rising edge of the conditioned external signal sets `trig_captured`, and `conv_gate` follows `trig_captured`. A pin edge shows at the outputs SYNC_STAGES+1 clock edges after it is applied.
- R7: With `edge_mode` = 0, `conv_gate` follows the conditioned external level with the same latency as R6. Its first rise also sets `trig_captured`.
- R8: Once `trig_captured` is set, further triggers have no effect until `trig_clear` = 1. That clears the flag at the next edge, and a clear wins over a trigger in the same cycle.
- R9: The analog mode field {`hmode`,`clo_en`,`chi_en`} = 000 selects positive hysteresis. The analog signal goes high when `cmp_above_hi` is 1 and low when `cmp_below_lo` is 1, and otherwise holds.
- R10: Mode 100 selects negative hysteresis. The analog signal goes high on `cmp_below_lo` and low on `cmp_above_hi`, and otherwise holds.
- R11: Mode x10 (negative slope) makes the analog signal equal to `cmp_below_lo`. Mode x01 (positive slope) makes it equal to `cmp_above_hi`.
- R12: Mode x11 (window) makes the analog signal high only while both comparator results are 0. Analog results reach `conv_gate` in level mode SYNC_STAGES+2 edges after they are applied.
- R13: Across arbitrary sequences of source, mode, polarity, enable, clear and input changes, both outputs match the behaviour above on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Trigger origin: 00 off, 01 software, 10 digital pin, 11 analog |
| polarity | input | 1 | 1 inverts the external signal |
| edge_mode | input | 1 | 1 edge trigger, 0 level gate |
| ext_en | input | 1 | Enables the external (pin or analog) origin |
| hmode | input | 1 | Analog mode field, upper bit |
| clo_en | input | 1 | Analog mode field, middle bit |
| chi_en | input | 1 | Analog mode field, lower bit |
| trig_clear | input | 1 | Write-one clear of the captured flag |
| sw_trig | input | 1 | Software trigger strobe |
| ext_trig_in | input | 1 | External digital trigger pin, asynchronous |
| cmp_above_hi | input | 1 | Comparator: analog input above high threshold, asynchronous |
| cmp_below_lo | input | 1 | Comparator: analog input below low threshold, asynchronous |
| conv_gate | output | 1 | Conversion gate / start permission |
| trig_captured | output | 1 | Trigger-captured flag |

## Verification
The bench builds the unit with SYNC_STAGES = 3 rather than the default 2. The latency checks therefore show that every pin and comparator delay tracks the parameter and is not fixed at two flops. With three stages a digital edge lands four edges after it is applied and an analog change five edges after. This separates a missing or extra synchronizer stage from a fault in the analog function register. The longer run of random stimulus switches source, mode and clear while signals are still in flight through the chain. This exposes false edges and clear-versus-trigger collisions.

// File: rtl/adc_trig_gate.sv
module adc_trig_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       polarity,
  input  logic       edge_mode,
  input  logic       ext_en,
  input  logic       hmode,
  input  logic       clo_en,
  input  logic       chi_en,
  input  logic       trig_clear,
  input  logic       sw_trig,
  input  logic       ext_trig_in,
  input  logic       cmp_above_hi,
  input  logic       cmp_below_lo,
  output logic       conv_gate,
  output logic       trig_captured
);

  localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [NS-1:0] ext_sh, hi_sh, lo_sh;
  logic ext_s, hi_s, lo_s;
  logic ana_q, ana_d;
  logic cond_q, cond_now, raw_ext, fire;
  logic cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sh <= '0;
      hi_sh  <= '0;
      lo_sh  <= '0;
    end else begin
      ext_sh <= {ext_sh[NS-2:0], ext_trig_in};
      hi_sh  <= {hi_sh[NS-2:0], cmp_above_hi};
      lo_sh  <= {lo_sh[NS-2:0], cmp_below_lo};
    end
  end

  assign ext_s = ext_sh[NS-1];
  assign hi_s  = hi_sh[NS-1];
  assign lo_s  = lo_sh[NS-1];

  always_comb begin
    if (chi_en && clo_en)  ana_d = !hi_s && !lo_s;
    else if (clo_en)       ana_d = lo_s;
    else if (chi_en)       ana_d = hi_s;
    else if (!hmode)       ana_d = hi_s ? 1'b1 : (lo_s ? 1'b0 : ana_q);
    else                   ana_d = lo_s ? 1'b1 : (hi_s ? 1'b0 : ana_q);
  end

  assign raw_ext  = src_sel[0] ? ana_q : ext_s;
  assign cond_now = ext_en & src_sel[1] & (raw_ext ^ polarity);
  assign fire     = (src_sel == 2'b01) ? sw_trig : (cond_now & ~cond_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ana_q  <= 1'b0;
      cond_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      ana_q  <= ana_d;
      cond_q <= cond_now;
      cap_q  <= !trig_clear && (cap_q || fire);
    end
  end

  assign trig_captured = cap_q;
  assign conv_gate = (src_sel == 2'b00) ? 1'b0 :
                     ((src_sel == 2'b01) || edge_mode) ? cap_q : cond_q;

endmodule

// File: rtl/adc_trig_gate_chk.sv
module adc_trig_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] src_sel,
  input logic       edge_mode,
  input logic       ext_en,
  input logic       sw_trig,
  input logic       trig_clear,
  input logic       conv_gate,
  input logic       trig_captured
);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_clear |=> !trig_captured);

  assert_hold_captured_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_captured && !trig_clear) |=> trig_captured);

  assert_sw_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b01 && sw_trig && !trig_clear) |=> trig_captured);

  assert_off_no_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b00 && !trig_captured) |=> !trig_captured);

  assert_disabled_no_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel[1] && !ext_en) ##1 (src_sel[1] && !edge_mode) |-> !conv_gate);

endmodule

bind adc_trig_gate adc_trig_gate_chk u_chk (.*);

// File: tb/adc_trig_gate_tb.sv
module adc_trig_gate_tb;
  localparam int SYNC = 3;
  localparam int NS   = (SYNC < 2) ? 2 : SYNC;

  logic clk = 0, rst_n = 0;
  logic [1:0] src_sel = 0;
  logic polarity = 0, edge_mode = 0, ext_en = 0, hmode = 0, clo_en = 0, chi_en = 0;
  logic trig_clear = 0, sw_trig = 0, ext_trig_in = 0, cmp_above_hi = 0, cmp_below_lo = 0;
  logic conv_gate, trig_captured;

  adc_trig_gate #(.SYNC_STAGES(SYNC)) u_dut (.*);

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";

  bit q_ext[$], q_hi[$], q_lo[$];
  bit m_ext = 0, m_hi = 0, m_lo = 0, m_ana = 0, m_cond = 0, m_cap = 0;

  function automatic void model_reset();
    q_ext = {}; q_hi = {}; q_lo = {};
    for (int i = 0; i < NS - 1; i++) begin
      q_ext.push_back(0); q_hi.push_back(0); q_lo.push_back(0);
    end
    m_ext = 0; m_hi = 0; m_lo = 0; m_ana = 0; m_cond = 0; m_cap = 0;
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    bit cn, ev, na, src_ext;
    if (!rst_n) model_reset();
    else begin
      src_ext = src_sel[0] ? m_ana : m_ext;
      cn = ext_en && src_sel[1] && (src_ext != polarity);
      if (src_sel == 2'b01) ev = sw_trig;
      else ev = cn && !m_cond;
      case ({hmode, clo_en, chi_en})
        3'b000: na = m_hi ? 1 : (m_lo ? 0 : m_ana);
        3'b100: na = m_lo ? 1 : (m_hi ? 0 : m_ana);
        3'b010, 3'b110: na = m_lo;
        3'b001, 3'b101: na = m_hi;
        default: na = !m_hi && !m_lo;
      endcase
      m_cap = trig_clear ? 0 : (m_cap || ev);
      m_cond = cn;
      m_ana = na;
      q_ext.push_back(ext_trig_in); m_ext = q_ext.pop_front();
      q_hi.push_back(cmp_above_hi); m_hi = q_hi.pop_front();
      q_lo.push_back(cmp_below_lo); m_lo = q_lo.pop_front();
    end
  end

  function automatic bit exp_gate();
    if (src_sel == 2'b00) return 0;
    if (src_sel == 2'b01 || edge_mode) return m_cap;
    return m_cond;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (conv_gate !== exp_gate() || trig_captured !== m_cap) begin
        errors++;
        $display("FAIL %s cycle %0d: gate=%0b exp=%0b captured=%0b exp=%0b",
                 cur_req, cycles, conv_gate, exp_gate(), trig_captured, m_cap);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic expect_out(string req, bit g, bit c);
    checks++;
    if (conv_gate !== g || trig_captured !== c) begin
      errors++;
      $display("FAIL %s: gate=%0b exp=%0b captured=%0b exp=%0b", req, conv_gate, g, trig_captured, c);
    end
  endtask

  task automatic do_clear();
    trig_clear = 1; tick(); trig_clear = 0; tick();
  endtask

  task automatic set_mode(bit h, bit lo_e, bit hi_e);
    hmode = h; clo_en = lo_e; chi_en = hi_e;
  endtask

  initial begin
    tick(3);
    cur_req = "R1";
    rst_n = 1; #1;
    expect_out("R1", 0, 0);
    tick(2);

    cur_req = "R2";
    src_sel = 2'b00; ext_en = 1; edge_mode = 1;
    sw_trig = 1; ext_trig_in = 1; tick(); sw_trig = 0; tick(6);
    expect_out("R2", 0, 0);
    ext_trig_in = 0; tick(6);

    cur_req = "R3";
    ext_en = 0; src_sel = 2'b01;
    sw_trig = 1; tick(); sw_trig = 0;
    expect_out("R3", 1, 1);
    do_clear();
    expect_out("R8", 0, 0);

    cur_req = "R4";
    src_sel = 2'b10; ext_en = 0; edge_mode = 1;
    ext_trig_in = 1; tick(8); expect_out("R4", 0, 0);
    edge_mode = 0; tick(3); expect_out("R4", 0, 0);
    ext_trig_in = 0; tick(6);

    cur_req = "R6";
    ext_en = 1; edge_mode = 1; polarity = 0; tick(2);
    ext_trig_in = 1; tick(NS);
    expect_out("R6", 0, 0);
    tick();
    expect_out("R6", 1, 1);

    cur_req = "R8";
    ext_trig_in = 0; tick(3); ext_trig_in = 1; tick(8);
    expect_out("R8", 1, 1);
    do_clear();
    expect_out("R8", 0, 0);
    ext_trig_in = 0; tick(NS - 1);
    ext_trig_in = 1; tick(NS);
    trig_clear = 1; tick(); trig_clear = 0;
    expect_out("R8", 0, 0);
    tick(4);
    expect_out("R8", 0, 0);

    cur_req = "R5";
    polarity = 1; tick(6); do_clear();
    ext_trig_in = 0; tick(NS + 1);
    expect_out("R5", 1, 1);
    do_clear();

    cur_req = "R7";
    edge_mode = 0; polarity = 0; ext_trig_in = 0; tick(6); do_clear();
    ext_trig_in = 1; tick(NS);
    expect_out("R7", 0, 0);
    tick();
    expect_out("R7", 1, 1);
    ext_trig_in = 0; tick(NS + 1);
    expect_out("R7", 0, 1);
    do_clear();
    polarity = 1; tick(NS + 2);
    expect_out("R5", 1, 1);

    cur_req = "R9";
    polarity = 0; src_sel = 2'b11; set_mode(0, 0, 0);
    cmp_above_hi = 0; cmp_below_lo = 1; tick(8); do_clear();
    cmp_below_lo = 0; cmp_above_hi = 1; tick(NS + 1);
    expect_out("R9", 0, 0);
    tick();
    expect_out("R9", 1, 1);
    cmp_above_hi = 0; tick(8);
    expect_out("R9", 1, 1);
    cmp_below_lo = 1; tick(NS + 2);
    expect_out("R9", 0, 1);

    cur_req = "R10";
    set_mode(1, 0, 0); tick(NS + 2);
    expect_out("R10", 1, 1);
    cmp_below_lo = 0; tick(8);
    expect_out("R10", 1, 1);
    cmp_above_hi = 1; tick(NS + 2);
    expect_out("R10", 0, 1);

    cur_req = "R11";
    set_mode(0, 1, 0); cmp_above_hi = 1; cmp_below_lo = 0; tick(8);
    expect_out("R11", 0, 1);
    cmp_below_lo = 1; cmp_above_hi = 0; tick(NS + 2);
    expect_out("R11", 1, 1);
    set_mode(1, 0, 1); tick(NS + 2);
    expect_out("R11", 0, 1);
    cmp_above_hi = 1; cmp_below_lo = 0; tick(NS + 2);
    expect_out("R11", 1, 1);

    cur_req = "R12";
    set_mode(0, 1, 1); tick(NS + 2);
    expect_out("R12", 0, 1);
    cmp_above_hi = 0; cmp_below_lo = 0; tick(NS + 2);
    expect_out("R12", 1, 1);
    cmp_below_lo = 1; tick(NS + 2);
    expect_out("R12", 0, 1);

    cur_req = "R13";
    for (int i = 0; i < 4000; i++) begin
      bit [15:0] r = 16'($urandom);
      if (r[15:12] == 0) src_sel = r[1:0];
      if (r[11:9] == 0) begin polarity = r[2]; edge_mode = r[3]; ext_en = r[4] | r[5]; end
      if (r[8:6] == 0) set_mode(r[0], r[1], r[2]);
      trig_clear = (r[5:2] == 0);
      sw_trig = r[6] & r[7] & r[8];
      if (r[9] & r[10]) ext_trig_in = ~ext_trig_in;
      if (r[11] & r[12]) cmp_above_hi = ~cmp_above_hi;
      if (r[13] & r[14]) cmp_below_lo = ~cmp_below_lo;
      if (cmp_above_hi && cmp_below_lo) cmp_below_lo = 0;
      tick();
    end
    trig_clear = 0; sw_trig = 0; tick(4);
    finish_run();
  end
endmodule